// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block decides the result of a two-input single-precision floating-point operation when at least one operand is a NaN. It classifies both operands as number, quiet NaN or signalling NaN, picks one of them under a selectable priority policy, and quiets the pick before it leaves the block. It also raises an invalid-operation flag. The datapath logic is combinational. The result and the flag are captured in one output register, so an arithmetic pipeline can drop the block in beside its own result stage.

The caller sets the meaning of the signalling bit with a polarity input. A default-NaN mode replaces every result with a fixed canonical NaN. The block does no arithmetic on ordinary numbers and takes no trap.

Top module: `nan_propagate`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `nan_out` becomes 0 and `invalid` becomes 0.
- R2: `nan_out` and `invalid` reflect the inputs sampled at a rising edge, and are visible from that edge until the next one (one cycle of latency).
- R3: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are not all zero. A NaN is signalling when bit 22 equals `sig_pol`, and quiet otherwise.
- R4: `invalid` is 1 exactly when at least one operand is a signalling NaN. This holds in every policy and also when `dflt_en` is 1.
- R5: When `dflt_en` is 1, `nan_out` is the default NaN whatever the operands are. The default NaN is 32'h7FC00000 when `sig_pol` is 0 and 32'h7FBFFFFF when `sig_pol` is 1.
- R6: Under policy 2'b00, and under policy 2'b11, which behaves the same way, the block takes the first match of these: a signalling a, a signalling b, a quiet a; otherwise it takes b.
- R7: Under policy 2'b01, the block takes a if a is any NaN, and takes b otherwise.
- R8: Under policy 2'b10, when one operand is a signalling NaN and the other is a quiet NaN, the quiet one is taken. When one operand is a NaN and the other is not, the NaN is taken.
- R9: Under policy 2'b10, when both operands are NaNs of the same kind, the block takes the one whose bits 30:0 are larger as an unsigned value. When those bits are equal, it takes the operand with sign bit 0.
- R10: A chosen signalling NaN is quieted before output. With `sig_pol` 0, bit 22 is set and every other bit is kept. With `sig_pol` 1, the output is the default NaN of R5. A chosen quiet NaN is output unchanged.
- R11: With `dflt_en` 0 and neither operand a NaN, `nan_out` equals `op_a` and `invalid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 32 | First operand, binary32 |
| op_b | input | 32 | Second operand, binary32 |
| policy | input | 2 | Priority policy select |
| dflt_en | input | 1 | Default-NaN mode enable |
| sig_pol | input | 1 | Value of bit 22 that marks a NaN as signalling |
| nan_out | output | 32 | Selected and quieted NaN result |
| invalid | output | 1 | Invalid-operation flag |

## Verification
Both `nan_out` and `invalid` are due one cycle after the operands are presented. They come from the register that captures the inputs at the rising edge following the drive. The bench changes inputs on a falling edge and compares the outputs on the next falling edge, half a cycle after that capture. It therefore never reads a value in the cycle where it could still be changing. Every class pairing is run under every policy, both polarities and both default-mode settings, and ties and near-ties in magnitude are driven as directed cases.

// File: rtl/nanprop_pkg.sv
// Shared types for the NaN result selector.
// Assumes binary32 layout unless the modules are given other widths.
package nanprop_pkg;

    // Operand class as seen by the selector
    typedef enum logic [1:0] {
        CLS_NUM  = 2'd0,
        CLS_QNAN = 2'd1,
        CLS_SNAN = 2'd2
    } nan_cls_e;

    // Priority policies
    typedef enum logic [1:0] {
        POL_SIGNAL_FIRST = 2'd0,
        POL_A_FIRST      = 2'd1,
        POL_MAGNITUDE    = 2'd2,
        POL_SIGNAL_ALT   = 2'd3
    } nan_policy_e;

endpackage

// File: rtl/nanprop_classify.sv
// Classifies one operand as a number, a quiet NaN or a signalling NaN.
// Assumes the top fraction bit carries the quiet/signal mark and sig_pol
// gives the value of that bit that means "signalling".
module nanprop_classify
    import nanprop_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] opnd,
    input  logic                  sig_pol,
    output nan_cls_e              cls
);
    localparam int TOP_FRAC = FRAC_W - 1;

    logic exp_full;
    logic frac_zero;

    // Field tests on exponent and fraction
    always_comb begin
        exp_full  = &opnd[EXP_W+FRAC_W-1:FRAC_W];
        frac_zero = (opnd[FRAC_W-1:0] == '0);
    end

    // Class from the field tests and polarity
    always_comb begin
        if (!exp_full || frac_zero)
            cls = CLS_NUM;
        else if (opnd[TOP_FRAC] == sig_pol)
            cls = CLS_SNAN;
        else
            cls = CLS_QNAN;
    end
endmodule

// File: rtl/nanprop_choose.sv
// Decides which operand supplies the result under the selected policy.
// Assumes classes come from nanprop_classify; pick_b = 1 selects operand b.
module nanprop_choose
    import nanprop_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] opnd_a,
    input  logic [EXP_W+FRAC_W:0] opnd_b,
    input  nan_cls_e              cls_a,
    input  nan_cls_e              cls_b,
    input  logic [1:0]            policy,
    output logic                  pick_b
);
    localparam int MAG_W = EXP_W + FRAC_W;
    localparam int SGN   = EXP_W + FRAC_W;

    logic a_wins_mag;

    // Magnitude ranking with tie broken towards the positive sign
    always_comb begin
        if (opnd_a[MAG_W-1:0] != opnd_b[MAG_W-1:0])
            a_wins_mag = (opnd_a[MAG_W-1:0] > opnd_b[MAG_W-1:0]);
        else
            a_wins_mag = !opnd_a[SGN] && opnd_b[SGN];
    end

    // Policy decode
    always_comb begin
        unique case (nan_policy_e'(policy))
            POL_A_FIRST: begin
                pick_b = (cls_a == CLS_NUM);
            end
            POL_MAGNITUDE: begin
                if (cls_a == CLS_NUM)
                    pick_b = 1'b1;
                else if (cls_b == CLS_NUM)
                    pick_b = 1'b0;
                else if (cls_a != cls_b)
                    pick_b = (cls_b == CLS_QNAN);
                else
                    pick_b = !a_wins_mag;
            end
            default: begin
                if (cls_a == CLS_SNAN)
                    pick_b = 1'b0;
                else if (cls_b == CLS_SNAN)
                    pick_b = 1'b1;
                else
                    pick_b = (cls_a != CLS_QNAN);
            end
        endcase
    end
endmodule

// File: rtl/nanprop_quiet.sv
// Produces the outgoing value: default NaN, quieted pick or unchanged pick.
// Assumes is_snan describes the picked operand under the current polarity.
module nanprop_quiet #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] picked,
    input  logic                  is_snan,
    input  logic                  sig_pol,
    input  logic                  dflt_en,
    output logic [EXP_W+FRAC_W:0] result
);
    localparam int W        = 1 + EXP_W + FRAC_W;
    localparam int TOP_FRAC = FRAC_W - 1;

    logic [W-1:0] dflt_nan;
    logic [W-1:0] set_mark;

    // Canonical NaN for each polarity
    always_comb begin
        dflt_nan = '0;
        dflt_nan[W-2:FRAC_W] = '1;
        if (sig_pol)
            dflt_nan[TOP_FRAC-1:0] = '1;
        else
            dflt_nan[TOP_FRAC] = 1'b1;
    end

    // Quiet form that keeps payload and sign
    always_comb begin
        set_mark = picked;
        set_mark[TOP_FRAC] = 1'b1;
    end

    // Output selection
    always_comb begin
        if (dflt_en)
            result = dflt_nan;
        else if (is_snan && sig_pol)
            result = dflt_nan;
        else if (is_snan)
            result = set_mark;
        else
            result = picked;
    end
endmodule

// File: rtl/nan_propagate.sv
// Top of the two-operand NaN result selector. Classifies both operands,
// picks one by policy, quiets it and registers result and invalid flag.
// Assumes at least one operand is a NaN; otherwise op_a passes through.
module nan_propagate
    import nanprop_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [EXP_W+FRAC_W:0]     op_a,
    input  logic [EXP_W+FRAC_W:0]     op_b,
    input  logic [1:0]                policy,
    input  logic                      dflt_en,
    input  logic                      sig_pol,
    output logic [EXP_W+FRAC_W:0]     nan_out,
    output logic                      invalid
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic     [W-1:0] opnds [2];
    nan_cls_e         cls   [2];
    logic             pick_b;
    logic     [W-1:0] picked;
    logic             picked_snan;
    logic             any_nan;
    logic     [W-1:0] quiet_val;
    logic     [W-1:0] next_out;
    logic             next_inv;

    // Gather operands for the classifier array
    always_comb begin
        opnds[0] = op_a;
        opnds[1] = op_b;
    end

    for (genvar i = 0; i < 2; i++) begin : g_cls
        nanprop_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .opnd    (opnds[i]),
            .sig_pol (sig_pol),
            .cls     (cls[i])
        );
    end

    nanprop_choose #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_choose (
        .opnd_a (op_a),
        .opnd_b (op_b),
        .cls_a  (cls[0]),
        .cls_b  (cls[1]),
        .policy (policy),
        .pick_b (pick_b)
    );

    // Route the chosen operand and its class
    always_comb begin
        picked      = pick_b ? op_b : op_a;
        picked_snan = pick_b ? (cls[1] == CLS_SNAN) : (cls[0] == CLS_SNAN);
        any_nan     = (cls[0] != CLS_NUM) || (cls[1] != CLS_NUM);
    end

    nanprop_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
        .picked  (picked),
        .is_snan (picked_snan),
        .sig_pol (sig_pol),
        .dflt_en (dflt_en),
        .result  (quiet_val)
    );

    // Next-state values, with pass-through when no NaN is present
    always_comb begin
        next_inv = (cls[0] == CLS_SNAN) || (cls[1] == CLS_SNAN);
        if (!any_nan && !dflt_en)
            next_out = op_a;
        else
            next_out = quiet_val;
    end

    // Output register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nan_out <= '0;
            invalid <= 1'b0;
        end else begin
            nan_out <= next_out;
            invalid <= next_inv;
        end
    end
endmodule

// File: rtl/nan_propagate_chk.sv
// Property checker for nan_propagate, bound to every instance below.
// Assumes the default binary32 widths.
module nan_propagate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic [1:0]  policy,
    input logic        dflt_en,
    input logic        sig_pol,
    input logic [31:0] nan_out,
    input logic        invalid
);
    logic a_nan, b_nan, a_sig, b_sig, out_sig_now;

    // Independent view of operand classes
    always_comb begin
        a_nan = (op_a[30:23] == 8'hFF) && (op_a[22:0] != 23'd0);
        b_nan = (op_b[30:23] == 8'hFF) && (op_b[22:0] != 23'd0);
        a_sig = a_nan && (op_a[22] == sig_pol);
        b_sig = b_nan && (op_b[22] == sig_pol);
        out_sig_now = (nan_out[30:23] == 8'hFF) && (nan_out[22:0] != 23'd0);
    end

    a_r4_flag_on_signal: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(a_sig || b_sig) |-> invalid);

    a_r4_no_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!a_sig && !b_sig) |-> !invalid);

    a_r5_default_value: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dflt_en) |->
        nan_out == ($past(sig_pol) ? 32'h7FBFFFFF : 32'h7FC00000));

    a_r10_never_signal: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(a_nan || b_nan) |->
        !(out_sig_now && nan_out[22] == $past(sig_pol)));

    a_r7_quiet_a_passes: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(policy == 2'b01 && !dflt_en && a_nan && !a_sig) |->
        nan_out == $past(op_a));
endmodule

bind nan_propagate nan_propagate_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_a    (op_a),
    .op_b    (op_b),
    .policy  (policy),
    .dflt_en (dflt_en),
    .sig_pol (sig_pol),
    .nan_out (nan_out),
    .invalid (invalid)
);

// File: tb/nan_propagate_tb.sv
`timescale 1ns/1ps
module nan_propagate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [1:0]  policy = '0;
    logic        dflt_en = 1'b0, sig_pol = 1'b0;
    logic [31:0] nan_out;
    logic        invalid;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nan_propagate u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .policy(policy), .dflt_en(dflt_en), .sig_pol(sig_pol),
        .nan_out(nan_out), .invalid(invalid)
    );

    // Reference model built from the requirements: returns {invalid, result}
    function automatic logic [32:0] expect_of(logic [31:0] a, logic [31:0] b,
                                              logic [1:0] pol, logic dm, logic sp);
        logic an, bn, as_, bs_, aq, bq, take_b, a_big, sel_s;
        logic [31:0] dn, sel;
        an = (a[30:23] == 8'hFF) && (a[22:0] != 0);       // R3
        bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        as_ = an && (a[22] == sp); aq = an && !as_;
        bs_ = bn && (b[22] == sp); bq = bn && !bs_;
        dn = sp ? 32'h7FBFFFFF : 32'h7FC00000;             // R5
        if (dm) return {as_ | bs_, dn};
        if (!an && !bn) return {1'b0, a};                  // R11
        a_big = (a[30:0] > b[30:0]) || ((a[30:0] == b[30:0]) && (a < b));
        case (pol)
            2'd1: take_b = !an;                            // R7
            2'd2: begin                                    // R8 R9
                if (as_) take_b = bs_ ? !a_big : bq;
                else if (aq) take_b = bq ? !a_big : 1'b0;
                else take_b = 1'b1;
            end
            default: take_b = as_ ? 1'b0 : (bs_ ? 1'b1 : !aq); // R6
        endcase
        sel = take_b ? b : a;
        sel_s = take_b ? bs_ : as_;
        if (sel_s) sel = sp ? dn : (sel | 32'h0040_0000); // R10
        return {as_ | bs_, sel};
    endfunction

    // Random operand of a given class: 0 number, 1 quiet NaN, 2 signalling NaN
    function automatic logic [31:0] make_op(int cls, logic sp);
        logic [31:0] v;
        v = $urandom;
        if (cls == 0) begin
            if (v[30:23] == 8'hFF) v[30:23] = 8'h80;
        end else begin
            v[30:23] = 8'hFF;
            v[22] = (cls == 2) ? sp : !sp;
            if (v[22:0] == 0) v[0] = 1'b1;
        end
        return v;
    endfunction

    task automatic check(string req, logic [31:0] exp_v, logic exp_i);
        checks++;
        if (nan_out !== exp_v || invalid !== exp_i) begin
            failures++;
            $display("FAIL %s: got out=%h inv=%b expected out=%h inv=%b",
                     req, nan_out, invalid, exp_v, exp_i);
        end
    endtask

    // Drive one vector, wait one cycle, compare
    task automatic run(string req, logic [31:0] a, logic [31:0] b,
                       logic [1:0] pol, logic dm, logic sp);
        logic [32:0] e;
        @(negedge clk);
        op_a = a; op_b = b; policy = pol; dflt_en = dm; sig_pol = sp;
        e = expect_of(a, b, pol, dm, sp);
        @(negedge clk);
        check(req, e[31:0], e[32]);
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R1: reset clears outputs even with a signalling operand present
        op_a = 32'h7F800001; op_b = 32'h7FA00000;
        repeat (3) @(negedge clk);
        check("R1", 32'h0, 1'b0);
        rst_n = 1'b1;

        // R2: value appears one cycle later and holds until next edge
        run("R2", 32'h7FC12345, 32'h3F800000, 2'd0, 1'b0, 1'b0);

        // R5 R4: default mode with signalling and quiet operands
        run("R5_R4", 32'h7F800005, 32'h7FC00000, 2'd2, 1'b1, 1'b0);
        run("R5", 32'h7FC00001, 32'h7FC00002, 2'd1, 1'b1, 1'b1);

        // R9: ties on magnitude resolved by sign, and larger magnitude wins
        run("R9", 32'h7FC00001, 32'hFFC00001, 2'd2, 1'b0, 1'b0);
        run("R9", 32'hFFC00001, 32'h7FC00001, 2'd2, 1'b0, 1'b0);
        run("R9", 32'h7FC00002, 32'hFFC00005, 2'd2, 1'b0, 1'b0);
        run("R9_R10", 32'h7F800003, 32'hFF800007, 2'd2, 1'b0, 1'b0);

        // R8: signalling versus quiet yields the quiet one
        run("R8", 32'h7F800009, 32'hFFC00001, 2'd2, 1'b0, 1'b0);
        // R6: policy 3 equals policy 0
        run("R6", 32'h7FC00001, 32'h7F800002, 2'd3, 1'b0, 1'b0);
        // R7: quiet a beats signalling b
        run("R7", 32'h7FC00001, 32'h7F800002, 2'd1, 1'b0, 1'b0);
        // R10: signalling pick under polarity 1 becomes default NaN
        run("R10", 32'h7FC00001, 32'h7F800002, 2'd0, 1'b0, 1'b1);
        // R11: no NaN passes a through
        run("R11", 32'h3F800000, 32'hC0000000, 2'd2, 1'b0, 1'b0);
        // R3: all-ones exponent, zero fraction is a number (infinity)
        run("R3", 32'h7F800000, 32'h7FC00003, 2'd1, 1'b0, 1'b0);

        // R6 R7 R8 R9 R4: every class pairing under every policy and mode
        for (int pol = 0; pol < 4; pol++)
            for (int sp = 0; sp < 2; sp++)
                for (int dm = 0; dm < 2; dm++)
                    for (int ca = 0; ca < 3; ca++)
                        for (int cb = 0; cb < 3; cb++)
                            for (int k = 0; k < 3; k++)
                                run("R4_R6_R7_R8", make_op(ca, sp[0]), make_op(cb, sp[0]),
                                    pol[1:0], dm[0], sp[0]);

        // R9: random same-magnitude operands with opposite signs
        for (int k = 0; k < 200; k++) begin
            logic [31:0] x;
            x = make_op(1 + ($urandom % 2), 1'b0);
            run("R9", x, x ^ 32'h8000_0000, 2'd2, 1'b0, 1'b0);
        end

        // R10: random mix
        for (int k = 0; k < 2000; k++) begin
            logic [31:0] x;
            x = $urandom;
            run("R10", make_op($urandom % 3, x[0]), make_op(1 + ($urandom % 2), x[0]),
                x[3:2], (x[7:4] == 0), x[0]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule